// File: doc/BRIEF.md
# BCH Sector Error Location Corrector

This block applies the output of an eight-error BCH decoder to a 512-byte sector held in an external RAM. The decoder reports its result as three 32-bit location words and one status word. The status word carries three items: a ready flag, a 4-bit error count and the top bits of the last location. The block unpacks up to eight 13-bit bit positions from these words and applies a fixed adjustment to each one. It then flips each addressed bit in the RAM with a read-modify-write. At the end it reports how many corrections it applied, or it reports that the sector cannot be corrected.

A request starts with a one-cycle `start_i` pulse. The block waits until the decoder's ready flag is set, then captures the words. It applies one correction per read and write pair. When it finishes, it raises `done_o` for one cycle with the final count.

Top module: `bch_err_fixer`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `done_o`, `uncorr_o`, `ram_rd_o` and `ram_wr_o` are low.
- R2: A `start_i` pulse is held pending while status bit 15 (the ready flag) is 0. No RAM access and no `done_o` occur until the flag reads 1, and the words are captured in that cycle.
- R3: The error count is status bits [13:10]. A count of 0 gives `done_o` with `fix_cnt_o` = 0 and no RAM access.
- R4: A count greater than 8 gives `uncorr_o` high in the `done_o` cycle, with `fix_cnt_o` = 0 and no RAM write.
- R5: Positions are read from the 104-bit vector {status[23:16], loc2_i, loc1_i, loc0_i}. Position k is bits [13k+12:13k] of that vector.
- R6: Each raw position is XORed with 3 before use. A result p flips bit p[2:0] of byte p[11:3].
- R7: An adjusted position of 4096 or more is skipped. It causes no RAM access and is not counted.
- R8: Only positions 0 to count-1 are used. Higher positions have no effect, and `fix_cnt_o` never exceeds 8.
- R9: Each correction reads the byte in one cycle and writes it back in the next cycle to the same address. Corrections run in position order, so two identical positions cancel and both still count.
- R10: `done_o` is a one-cycle pulse. In that cycle, `fix_cnt_o` equals the number of RAM writes made for the request.
- R11: A `start_i` pulse that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse |
| loc0_i | input | 32 | Location word 0 |
| loc1_i | input | 32 | Location word 1 |
| loc2_i | input | 32 | Location word 2 |
| status_i | input | 32 | Ready flag, error count, top location bits |
| ram_addr_o | output | 9 | Sector byte address |
| ram_rd_o | output | 1 | RAM read strobe, data returns next cycle |
| ram_rdata_i | input | 8 | RAM read data |
| ram_wr_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| fix_cnt_o | output | 4 | Corrections applied |
| uncorr_o | output | 1 | Sector uncorrectable, valid with done_o |

## Verification
The assertions check on every cycle that the block is quiet when idle. They also check that every write directly follows a read of the same address and that `done_o` lasts one cycle. Finally, they check that the reported count matches the writes actually made, and that an uncorrectable result made no writes. Some behaviours can only be shown by the bench's scenarios against a modelled RAM. These are the exact position unpacking and XOR adjustment, the skipping of out-of-range positions, and the count limiting which positions are used. They also include the cancelling of duplicate positions, waiting on the ready flag, and ignoring a second start.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SCAN,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } fix_state_e;
endpackage

// File: rtl/bch_pos_unpack.sv
module bch_pos_unpack #(
  parameter int WORD_W   = 32,
  parameter int POS_W    = 13,
  parameter int NUM_POS  = 8,
  parameter int TAIL_LSB = 16
) (
  input  logic [WORD_W-1:0]              loc0_i,
  input  logic [WORD_W-1:0]              loc1_i,
  input  logic [WORD_W-1:0]              loc2_i,
  input  logic [WORD_W-1:0]              status_i,
  output logic [NUM_POS-1:0][POS_W-1:0]  pos_o
);
  localparam int TOT_W  = POS_W * NUM_POS;
  localparam int TAIL_W = TOT_W - 3 * WORD_W;

  logic [TOT_W-1:0] flat;
  assign flat = {status_i[TAIL_LSB +: TAIL_W], loc2_i, loc1_i, loc0_i};

  // decoder reports positions with the two low bits inverted
  for (genvar k = 0; k < NUM_POS; k++) begin : g_pos
    assign pos_o[k] = flat[k*POS_W +: POS_W] ^ POS_W'(3);
  end
endmodule

// File: rtl/bch_pos_check.sv
module bch_pos_check #(
  parameter int POS_W        = 13,
  parameter int SECTOR_BYTES = 512,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
  input  logic [POS_W-1:0]  pos_i,
  output logic              in_range_o,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic [7:0]        bit_mask_o
);
  localparam int BIT_LIMIT = SECTOR_BYTES * 8;

  assign in_range_o  = pos_i < POS_W'(BIT_LIMIT);
  assign byte_addr_o = pos_i[ADDR_W+2:3];
  assign bit_mask_o  = 8'b1 << pos_i[2:0];
endmodule

// File: rtl/bch_fix_ctrl.sv
module bch_fix_ctrl
  import bch_fix_pkg::*;
#(
  parameter int NUM_POS = 8,
  parameter int CNT_W   = 4,
  localparam int SEL_W  = $clog2(NUM_POS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ready_i,
  input  logic [CNT_W-1:0] err_cnt_i,
  input  logic             in_range_i,
  output logic             latch_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             uncorr_o,
  output logic [CNT_W-1:0] fix_cnt_o
);
  fix_state_e       state_q;
  logic [CNT_W-1:0] n_q, idx_q, cnt_q;
  logic             unc_q;
  logic             too_many;

  assign too_many = err_cnt_i > CNT_W'(NUM_POS);
  assign latch_o  = (state_q == ST_ARM) && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      n_q     <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      unc_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_ARM;
        ST_ARM: if (ready_i) begin
          n_q     <= err_cnt_i;
          idx_q   <= '0;
          cnt_q   <= '0;
          unc_q   <= too_many;
          state_q <= too_many ? ST_DONE : ST_SCAN;
        end
        ST_SCAN: begin
          if (idx_q == n_q)    state_q <= ST_DONE;
          else if (in_range_i) state_q <= ST_READ;
          else                 idx_q   <= idx_q + 1'b1;
        end
        ST_READ: state_q <= ST_WRITE;
        ST_WRITE: begin
          cnt_q   <= cnt_q + 1'b1;
          idx_q   <= idx_q + 1'b1;
          state_q <= ST_SCAN;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_o     = idx_q[SEL_W-1:0];
  assign rd_o      = state_q == ST_READ;
  assign wr_o      = state_q == ST_WRITE;
  assign busy_o    = state_q != ST_IDLE;
  assign done_o    = state_q == ST_DONE;
  assign uncorr_o  = done_o && unc_q;
  assign fix_cnt_o = cnt_q;
endmodule

// File: rtl/bch_err_fixer.sv
module bch_err_fixer #(
  parameter int WORD_W       = 32,
  parameter int POS_W        = 13,
  parameter int NUM_POS      = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int CNT_W        = 4,
  parameter int CNT_LSB      = 10,
  parameter int RDY_BIT      = 15,
  parameter int TAIL_LSB     = 16,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] loc0_i,
  input  logic [WORD_W-1:0] loc1_i,
  input  logic [WORD_W-1:0] loc2_i,
  input  logic [WORD_W-1:0] status_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_rd_o,
  input  logic [7:0]        ram_rdata_i,
  output logic              ram_wr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  fix_cnt_o,
  output logic              uncorr_o
);
  localparam int SEL_W  = $clog2(NUM_POS);
  localparam int TAIL_W = POS_W * NUM_POS - 3 * WORD_W;

  logic [NUM_POS-1:0][POS_W-1:0] pos_d, pos_q;
  logic [POS_W-1:0]              cur_pos;
  logic [SEL_W-1:0]              sel;
  logic                          latch, in_range;
  logic [7:0]                    bit_mask;
  logic                          unused_status;

  assign unused_status = ^{status_i[WORD_W-1:TAIL_LSB+TAIL_W],
                           status_i[RDY_BIT-1:CNT_LSB+CNT_W],
                           status_i[CNT_LSB-1:0]};

  bch_pos_unpack #(
    .WORD_W(WORD_W), .POS_W(POS_W), .NUM_POS(NUM_POS), .TAIL_LSB(TAIL_LSB)
  ) u_unpack (
    .loc0_i(loc0_i), .loc1_i(loc1_i), .loc2_i(loc2_i),
    .status_i(status_i), .pos_o(pos_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= '0;
    else if (latch) pos_q <= pos_d;
  end

  assign cur_pos = pos_q[sel];

  bch_pos_check #(
    .POS_W(POS_W), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_check (
    .pos_i(cur_pos), .in_range_o(in_range),
    .byte_addr_o(ram_addr_o), .bit_mask_o(bit_mask)
  );

  bch_fix_ctrl #(
    .NUM_POS(NUM_POS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .ready_i(status_i[RDY_BIT]),
    .err_cnt_i(status_i[CNT_LSB +: CNT_W]),
    .in_range_i(in_range), .latch_o(latch), .sel_o(sel),
    .rd_o(ram_rd_o), .wr_o(ram_wr_o), .busy_o(busy_o),
    .done_o(done_o), .uncorr_o(uncorr_o), .fix_cnt_o(fix_cnt_o)
  );

  assign ram_wdata_o = ram_rdata_i ^ bit_mask;
endmodule

// File: rtl/bch_fix_chk.sv
module bch_fix_chk #(
  parameter int NUM_POS = 8,
  parameter int CNT_W   = 4,
  parameter int ADDR_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_rd_o,
  input logic              ram_wr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  fix_cnt_o,
  input logic              uncorr_o
);
  logic [CNT_W-1:0] wr_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wr_seen <= '0;
    else if (done_o)   wr_seen <= '0;
    else if (ram_wr_o) wr_seen <= wr_seen + 1'b1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ram_rd_o && !ram_wr_o && !done_o && !uncorr_o);

  p_uncorr_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |-> done_o && wr_seen == '0 && fix_cnt_o == '0);

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fix_cnt_o <= CNT_W'(NUM_POS));

  p_rmw_pair_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_rd_o |=> ram_wr_o && $stable(ram_addr_o));

  p_wr_after_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_wr_o |-> $past(ram_rd_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_cnt_matches_writes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fix_cnt_o == wr_seen);
endmodule

bind bch_err_fixer bch_fix_chk #(
  .NUM_POS(NUM_POS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ram_addr_o(ram_addr_o),
  .ram_rd_o(ram_rd_o), .ram_wr_o(ram_wr_o), .busy_o(busy_o),
  .done_o(done_o), .fix_cnt_o(fix_cnt_o), .uncorr_o(uncorr_o)
);

// File: tb/bch_err_fixer_test.sv
module bch_err_fixer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] loc0_i = '0, loc1_i = '0, loc2_i = '0, status_i = '0;
  logic [8:0]  ram_addr_o;
  logic        ram_rd_o, ram_wr_o, busy_o, done_o, uncorr_o;
  logic [7:0]  ram_rdata_i = '0, ram_wdata_o;
  logic [3:0]  fix_cnt_o;

  always #2 clk_i = ~clk_i;

  bch_err_fixer uut (.*);

  logic [7:0] mem    [512];
  logic [7:0] golden [512];
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  int n_tests = 0, n_fail = 0, cyc = 0;

  always @(posedge clk_i) begin
    if (ram_wr_o) mem[ram_addr_o] <= ram_wdata_o;
    if (ram_rd_o) ram_rdata_i <= mem[ram_addr_o];
    if (ram_rd_o) rd_cnt++;
    if (ram_wr_o) wr_cnt++;
    if (done_o)   done_cnt++;
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  typedef struct packed {
    logic [3:0]       n;
    logic [7:0][12:0] p;
    logic [3:0]       exp;
  } vec_t;

  // positions listed 7 down to 0
  localparam vec_t VEC [6] = '{
    '{4'd1, {13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd3}, 4'd1},
    '{4'd8, {13'd4000, 13'd17, 13'd4095, 13'd3000, 13'd2047, 13'd1000, 13'd205, 13'd100}, 4'd8},
    '{4'd3, {13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd10, 13'd5000, 13'd4097}, 4'd1},
    '{4'd2, {13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd50, 13'd50}, 4'd2},
    '{4'd4, {13'd7, 13'd6, 13'd5, 13'd4, 13'd400, 13'd300, 13'd200, 13'd100}, 4'd4},
    '{4'd8, {13'd4093, 13'd2, 13'd1, 13'd4092, 13'd0, 13'd8191, 13'd4096, 13'd4095}, 4'd6}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] n, input logic [7:0][12:0] p, input logic rdy);
    logic [103:0] flat;
    for (int k = 0; k < 8; k++) flat[k*13 +: 13] = p[k];
    loc0_i   = flat[31:0];
    loc1_i   = flat[63:32];
    loc2_i   = flat[95:64];
    status_i = {8'h00, flat[103:96], rdy, 1'b0, n, 10'h000};
  endtask

  task automatic init_mem(input int seed);
    for (int i = 0; i < 512; i++) begin
      mem[i]    = 8'(i * 37 + seed) ^ 8'h5a;
      golden[i] = mem[i];
    end
  endtask

  task automatic apply_golden(input logic [3:0] n, input logic [7:0][12:0] p);
    for (int k = 0; k < 8; k++) begin
      logic [12:0] q;
      q = p[k] ^ 13'd3;
      if (k < int'(n) && q < 13'd4096) golden[q[11:3]][q[2:0]] ^= 1'b1;
    end
  endtask

  task automatic pulse_start;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done;
    for (int i = 0; i < 400 && !done_o; i++) @(negedge clk_i);
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== golden[i]) d++;
    return d;
  endfunction

  initial begin
    int r0, w0, d0;
    init_mem(0);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!done_o && !busy_o && !ram_rd_o && !ram_wr_o && !uncorr_o, "R1 reset",
          {done_o, busy_o, ram_rd_o, ram_wr_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: R5 R6 R7 R8 R9 R10
    for (int v = 0; v < 6; v++) begin
      init_mem(v);
      apply_golden(VEC[v].n, VEC[v].p);
      load(VEC[v].n, VEC[v].p, 1'b1);
      w0 = wr_cnt;
      pulse_start();
      wait_done();
      check(done_o && fix_cnt_o == VEC[v].exp && !uncorr_o, "R5/R7/R8 count",
            fix_cnt_o, VEC[v].exp);
      check(wr_cnt - w0 == int'(VEC[v].exp), "R10 writes", wr_cnt - w0, VEC[v].exp);
      @(negedge clk_i);
      check(!done_o, "R10 pulse", done_o, 0);
      check(mem_diff() == 0, "R6/R9 sector contents", mem_diff(), 0);
    end

    // R3 zero count
    init_mem(9);
    load(4'd0, {8{13'd100}}, 1'b1);
    r0 = rd_cnt; w0 = wr_cnt;
    pulse_start();
    wait_done();
    check(done_o && fix_cnt_o == 0 && !uncorr_o, "R3 zero count", fix_cnt_o, 0);
    check(rd_cnt == r0 && wr_cnt == w0, "R3 no access", rd_cnt - r0 + wr_cnt - w0, 0);
    @(negedge clk_i);

    // R4 counts 9 and 15
    for (int c = 9; c <= 15; c += 6) begin
      init_mem(c);
      load(4'(c), {8{13'd20}}, 1'b1);
      w0 = wr_cnt;
      pulse_start();
      wait_done();
      check(done_o && uncorr_o && fix_cnt_o == 0, "R4 uncorrectable", uncorr_o, 1);
      check(wr_cnt == w0 && mem_diff() == 0, "R4 no writes", wr_cnt - w0, 0);
      @(negedge clk_i);
    end

    // R2 ready flag gating
    init_mem(3);
    load(4'd1, {8{13'd0}}, 1'b0);
    r0 = rd_cnt; d0 = done_cnt;
    pulse_start();
    repeat (6) @(negedge clk_i);
    check(busy_o && rd_cnt == r0 && done_cnt == d0, "R2 wait for ready",
          rd_cnt - r0 + done_cnt - d0, 0);
    load(4'd1, {13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd11}, 1'b1);
    apply_golden(4'd1, {13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd11});
    wait_done();
    check(done_o && fix_cnt_o == 1 && mem_diff() == 0, "R2 captured at ready",
          fix_cnt_o, 1);
    @(negedge clk_i);

    // R11 start while busy
    init_mem(5);
    apply_golden(VEC[1].n, VEC[1].p);
    load(VEC[1].n, VEC[1].p, 1'b1);
    pulse_start();
    repeat (3) @(negedge clk_i);
    load(4'd12, {8{13'd1}}, 1'b1);
    pulse_start();
    wait_done();
    check(done_o && fix_cnt_o == 8 && !uncorr_o, "R11 second start ignored",
          fix_cnt_o, 8);
    check(mem_diff() == 0, "R11 sector contents", mem_diff(), 0);
    d0 = done_cnt;
    repeat (10) @(negedge clk_i);
    check(!busy_o && done_cnt == d0 + 1, "R11 no extra run", done_cnt - d0, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule